// File: doc/BRIEF.md
# Length-Addressed Serial Register Port

This block is a slave serial port that carries no address or steering bits. An external master holds an active-low enable, clocks a stream of bits in most-significant-bit first, and releases the enable. The number of serial clock rising edges counted in that window picks the destination. A stream of 8 bits loads an 8-bit control register, 16 bits load a 16-bit divider register, and 24 bits load a 24-bit reference register. Any other length is discarded. The parallel outputs change only when the enable is released, so downstream logic never sees a half-shifted word.

The same transfer can read data back. When a read-select bit is set in the control register, the port shifts out an 8-bit status word followed by a ninth flag bit, or a 24-bit value, on the serial data output. The first bit is presented once the enable falls, and each falling serial clock edge advances to the next bit. The serial clock, data and enable inputs are asynchronous to the system clock. They pass through synchronisers, and their edges are detected in the system clock domain.

Top module: `lap_serial_port`

## Requirements
- R1: While the enable is low, each rising edge of the serial clock captures one serial data bit, and the bits are assembled most-significant bit first.
- R2: When the enable rises, a count of exactly 8 loads the control register, 16 loads the divider register and 24 loads the reference register. Each register receives the last bits shifted in.
- R3: When the enable rises after any other count (0, 12, 32 or any count other than 8, 16 or 24), all three registers keep their values.
- R4: The parallel register outputs hold their values throughout a transfer and change only after the enable rises.
- R5: Serial clock edges seen while the enable is high have no effect, and each transfer starts counting from zero.
- R6: The serial output enable (`sdo_oe_o`, 1 = driving, 0 = high-impedance) is 0 while the enable is high. It is also 0 during a transfer when neither read-select bit was set at the start of that transfer.
- R7: If control bit 7 is set when a transfer starts, `sdo_o` first presents status bit 7. Each falling serial clock edge then advances the output through bits 6 down to 0, then the flag bit, then zeros. This allows the status to be read with 8, 9 or 16 clocks.
- R8: If control bit 6 is set and bit 7 is clear, `sdo_o` presents the 24-bit value MSB first, advancing on each falling serial clock edge.
- R9: If control bits 7 and 6 are both set, the status readback is selected.
- R10: If the enable changes while the serial clock is high, the transfer is abandoned with no register update. Normal operation resumes once the enable is high and the serial clock is low.
- R11: The bit counter saturates rather than wrapping, so a 40-clock stream commits nothing.
- R12: The asynchronous active-low reset clears all three registers to zero and turns off the serial output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data in |
| sen_n_i | input | 1 | Active-low transfer enable |
| stat_i | input | 8 | Status word for readback |
| stat_flag_i | input | 1 | Ninth status bit, sent after status bit 0 |
| wide_i | input | 24 | 24-bit value for readback |
| ctl_o | output | 8 | Control register |
| div_o | output | 16 | Divider register |
| ref_o | output | 24 | Reference register |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high-impedance |

## Verification
The bench builds the block with its default parameters: register widths of 8, 16 and 24 bits, a counter that saturates at 33, and two synchroniser stages. With these values, streams longer than 32 clocks are within reach. A 40-clock stream tells saturation apart from a 5-bit wrap, because a wrapping counter would read it as 8 and load the control register. The serial clock runs slowly enough relative to the system clock that every synchroniser and edge-detect latency settles between edges. Readback is exercised with 8, 9, 16 and 24 clocks, so the same transfers also test the write commits that follow from their lengths.

// File: rtl/lap_pkg.sv
package lap_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_WIDE = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/lap_sync.sv
module lap_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_n[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_n;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lap_frame.sv
module lap_frame #(
  parameter int CTL_W   = 8,
  parameter int DIV_W   = 16,
  parameter int SH_W    = 24,
  parameter int CNT_SAT = 33
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_s,
  input  logic            sdi_s,
  input  logic            sen_n_s,
  output logic            start_o,
  output logic            act_o,
  output logic            sck_fall_o,
  output logic            commit_ctl_o,
  output logic            commit_div_o,
  output logic            commit_ref_o,
  output logic [SH_W-1:0] word_o
);
  localparam int CNT_W = $clog2(CNT_SAT + 1);
  localparam logic [CNT_W-1:0] N_CTL = CNT_W'(CTL_W);
  localparam logic [CNT_W-1:0] N_DIV = CNT_W'(DIV_W);
  localparam logic [CNT_W-1:0] N_REF = CNT_W'(SH_W);
  localparam logic [CNT_W-1:0] N_SAT = CNT_W'(CNT_SAT);

  logic            sck_d, sen_n_d;
  logic            sync_q, sync_n;
  logic            act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SH_W-1:0]  sh_q, sh_n;
  logic            sck_rise, sck_fall, sen_fall, sen_rise, commit;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign sen_fall = ~sen_n_s & sen_n_d;
  assign sen_rise = sen_n_s & ~sen_n_d;

  always_comb begin
    sync_n = sync_q;
    if (sen_n_s && !sck_s)                  sync_n = 1'b1;
    else if ((sen_fall || sen_rise) && sck_s) sync_n = 1'b0;

    act_n = act_q;
    if (sen_n_s)       act_n = 1'b0;
    else if (sen_fall) act_n = sync_q & ~sck_s;

    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (sen_n_s) begin
      cnt_n = '0;
      sh_n  = '0;
    end else if (act_q && sck_rise) begin
      sh_n = {sh_q[SH_W-2:0], sdi_s};
      if (cnt_q < N_SAT) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      sen_n_d <= 1'b1;
      sync_q  <= 1'b1;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      sck_d   <= sck_s;
      sen_n_d <= sen_n_s;
      sync_q  <= sync_n;
      act_q   <= act_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
    end
  end

  assign commit       = sen_rise & act_q & ~sck_s;
  assign commit_ctl_o = commit & (cnt_q == N_CTL);
  assign commit_div_o = commit & (cnt_q == N_DIV);
  assign commit_ref_o = commit & (cnt_q == N_REF);
  assign start_o      = sen_fall & sync_q & ~sck_s;
  assign act_o        = act_q;
  assign sck_fall_o   = sck_fall;
  assign word_o       = sh_q;

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n_s |=> (cnt_q == '0));
  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= N_SAT);
  // R2
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_ctl_o, commit_div_o, commit_ref_o}));
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_rise && sck_s) |-> !(commit_ctl_o || commit_div_o || commit_ref_o));
endmodule

// File: rtl/lap_readout.sv
module lap_readout
  import lap_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int RD_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              act_i,
  input  logic              sck_fall_i,
  input  logic              sel_stat_i,
  input  logic              sel_wide_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              stat_flag_i,
  input  logic [RD_W-1:0]   wide_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int PAD_W = RD_W - STAT_W - 1;

  rd_sel_e         sel_q, sel_n;
  logic [RD_W-1:0] sh_q, sh_n;
  logic [RD_W-1:0] stat_frame;

  assign stat_frame = {stat_i, stat_flag_i, {PAD_W{1'b0}}};

  always_comb begin
    sel_n = sel_q;
    sh_n  = sh_q;
    if (start_i) begin
      if (sel_stat_i) begin
        sel_n = RD_STAT;
        sh_n  = stat_frame;
      end else if (sel_wide_i) begin
        sel_n = RD_WIDE;
        sh_n  = wide_i;
      end else begin
        sel_n = RD_NONE;
        sh_n  = '0;
      end
    end else if (act_i && sck_fall_i) begin
      sh_n = {sh_q[RD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RD_NONE;
      sh_q  <= '0;
    end else begin
      sel_q <= sel_n;
      sh_q  <= sh_n;
    end
  end

  assign sdo_oe_o = act_i & (sel_q != RD_NONE);
  assign sdo_o    = sdo_oe_o & sh_q[RD_W-1];

  // R9
  stat_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && sel_stat_i) |=> (sel_q == RD_STAT));
endmodule

// File: rtl/lap_serial_port.sv
module lap_serial_port #(
  parameter int CTL_W       = 8,
  parameter int DIV_W       = 16,
  parameter int REF_W       = 24,
  parameter int STAT_W      = 8,
  parameter int CNT_SAT     = 33,
  parameter int SYNC_STAGES = 2,
  parameter int RD_STAT_BIT = 7,
  parameter int RD_WIDE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              sen_n_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              stat_flag_i,
  input  logic [REF_W-1:0]  wide_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [REF_W-1:0]  ref_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [2:0]       pins_s;
  logic             sck_s, sdi_s, sen_n_s;
  logic             start, act, sck_fall;
  logic             c_ctl, c_div, c_ref;
  logic [REF_W-1:0] word;
  logic [CTL_W-1:0] ctl_q, ctl_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [REF_W-1:0] ref_q, ref_n;

  lap_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sck_i, sdi_i, sen_n_i}),
    .q_o   (pins_s)
  );
  assign sck_s   = pins_s[2];
  assign sdi_s   = pins_s[1];
  assign sen_n_s = pins_s[0];

  lap_frame #(.CTL_W(CTL_W), .DIV_W(DIV_W), .SH_W(REF_W), .CNT_SAT(CNT_SAT)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_s        (sck_s),
    .sdi_s        (sdi_s),
    .sen_n_s      (sen_n_s),
    .start_o      (start),
    .act_o        (act),
    .sck_fall_o   (sck_fall),
    .commit_ctl_o (c_ctl),
    .commit_div_o (c_div),
    .commit_ref_o (c_ref),
    .word_o       (word)
  );

  always_comb begin
    ctl_n = c_ctl ? word[CTL_W-1:0] : ctl_q;
    div_n = c_div ? word[DIV_W-1:0] : div_q;
    ref_n = c_ref ? word            : ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      div_q <= '0;
      ref_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      div_q <= div_n;
      ref_q <= ref_n;
    end
  end

  lap_readout #(.STAT_W(STAT_W), .RD_W(REF_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .act_i       (act),
    .sck_fall_i  (sck_fall),
    .sel_stat_i  (ctl_q[RD_STAT_BIT]),
    .sel_wide_i  (ctl_q[RD_WIDE_BIT]),
    .stat_i      (stat_i),
    .stat_flag_i (stat_flag_i),
    .wide_i      (wide_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  assign ctl_o = ctl_q;
  assign div_o = div_q;
  assign ref_o = ref_q;

  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctl_q, div_q, ref_q}) |-> $past(sen_n_s));
  // R6
  sdo_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n_s |=> !sdo_oe_o);
endmodule

// File: tb/sim_lap_serial_port.sv
module sim_lap_serial_port;
  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, sdi = 1'b0, sen_n = 1'b1;
  logic [7:0]  stat = 8'h00;
  logic        flag = 1'b0;
  logic [23:0] wide = 24'h0;
  logic [7:0]  ctl;
  logic [15:0] dv;
  logic [23:0] rf;
  logic        sdo, sdo_oe;

  always #10 clk = ~clk;

  lap_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .sen_n_i(sen_n),
    .stat_i(stat), .stat_flag_i(flag), .wide_i(wide),
    .ctl_o(ctl), .div_o(dv), .ref_o(rf), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  int checks = 0, fails = 0;
  logic [7:0]  m_ctl = 0;
  logic [15:0] m_div = 0;
  logic [23:0] m_ref = 0;
  bit m_sync = 1, m_act = 0, m_rd = 0;
  bit q_bits[$];
  bit rd_q[$];
  int rd_i = 0;
  int settle = 4;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] a, logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  task automatic chk_regs(string tag);
    chk(ctl == m_ctl, tag, "ctl", 32'(ctl), 32'(m_ctl));
    chk(dv == m_div, tag, "div", 32'(dv), 32'(m_div));
    chk(rf == m_ref, tag, "ref", 32'(rf), 32'(m_ref));
  endtask

  // continuous per-cycle comparison of registers against the model (R4)
  always @(posedge clk) begin
    #2;
    if (settle > 0) settle--;
    else if (rst_n && !done) begin
      if (ctl !== m_ctl || dv !== m_div || rf !== m_ref) begin
        fails++;
        if (fails < 10)
          $display("FAIL R4 per-cycle actual=%h_%h_%h expected=%h_%h_%h",
                   ctl, dv, rf, m_ctl, m_div, m_ref);
      end
    end
  end

  task automatic begin_xfer();
    if (m_sync && !sck) begin
      m_act = 1;
      q_bits.delete();
      rd_q.delete();
      rd_i = 0;
      m_rd = m_ctl[7] | m_ctl[6];
      if (m_ctl[7]) begin
        for (int i = 7; i >= 0; i--) rd_q.push_back(stat[i]);
        rd_q.push_back(flag);
      end else if (m_ctl[6]) begin
        for (int i = 23; i >= 0; i--) rd_q.push_back(wide[i]);
      end
    end else begin
      m_act = 0;
      m_rd = 0;
    end
    sen_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic bit_xfer(bit b, string tag);
    bit e_oe, e;
    sdi = b;
    repeat (HP) @(negedge clk);
    e_oe = m_act && m_rd;
    chk(sdo_oe == e_oe, tag, "sdo_oe", 32'(sdo_oe), 32'(e_oe));
    if (e_oe) begin
      e = (rd_i < rd_q.size()) ? rd_q[rd_i] : 1'b0;
      chk(sdo == e, tag, "sdo", 32'(sdo), 32'(e));
    end
    sck = 1'b1;
    if (m_act) q_bits.push_back(b);
    repeat (HP) @(negedge clk);
    sck = 1'b0;
    rd_i++;
  endtask

  task automatic end_xfer();
    logic [63:0] v;
    repeat (HP) @(negedge clk);
    sen_n = 1'b1;
    settle = 8;
    if (m_act && !sck) begin
      v = 0;
      foreach (q_bits[i]) v = {v[62:0], q_bits[i]};
      if (q_bits.size() == 8)  m_ctl = v[7:0];
      if (q_bits.size() == 16) m_div = v[15:0];
      if (q_bits.size() == 24) m_ref = v[23:0];
    end
    m_act = 0;
    if (!sck) m_sync = 1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic xfer(logic [31:0] val, int n, string tag);
    begin_xfer();
    for (int i = n - 1; i >= 0; i--) bit_xfer((i < 32) ? val[i] : 1'b0, tag);
    end_xfer();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(ctl == 0 && dv == 0 && rf == 0, "R12", "regs in reset", {8'h0, ctl, dv[7:0], rf[7:0]}, 0);
    chk(sdo_oe == 0, "R12", "oe in reset", 32'(sdo_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 legal writes
    xfer(32'hA5C3, 16, "R2");   chk_regs("R2 div");
    xfer(32'h5A1234, 24, "R1"); chk_regs("R1 ref");
    xfer(32'h21, 8, "R2");      chk_regs("R2 ctl");
    xfer(32'h00F00D, 24, "R2"); chk_regs("R2 ref2");
    chk(sdo_oe == 0, "R6", "oe idle", 32'(sdo_oe), 0);

    // R3 illegal lengths
    xfer(32'hFFF, 12, "R3");       chk_regs("R3 12");
    xfer(32'h0, 0, "R3");          chk_regs("R3 0");
    xfer(32'hDEADBEEF, 32, "R3");  chk_regs("R3 32");
    // R11 40 clocks would wrap to 8 without saturation
    xfer(32'h000000FF, 40, "R11"); chk_regs("R11 40");

    // R5 clock edges while enable high
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1; repeat (HP) @(negedge clk);
      sck = 1'b0; repeat (HP) @(negedge clk);
    end
    chk_regs("R5 idle clocks");
    xfer(32'h1234, 16, "R5"); chk_regs("R5 div after idle clocks");

    // R7 status readback, 9 clocks then 16 then 8
    stat = 8'hB6; flag = 1'b1;
    xfer(32'h80, 8, "R2");  chk_regs("R2 ctl read-arm");
    xfer(32'h1AB, 9, "R7"); chk_regs("R7 9clk no commit");
    stat = 8'h4D; flag = 1'b0;
    xfer(32'h0F0F, 16, "R7"); chk_regs("R7 16clk");
    xfer(32'h80, 8, "R7");    chk_regs("R7 8clk");

    // R8 24-bit readback
    wide = 24'hC3A5F1;
    xfer(32'h40, 8, "R8");      chk_regs("R8 arm");
    xfer(32'h777777, 24, "R8"); chk_regs("R8 read");

    // R9 both set: status wins
    stat = 8'h93; flag = 1'b1; wide = 24'hFFFFFF;
    xfer(32'hC0, 8, "R9");  chk_regs("R9 arm");
    xfer(32'h000, 9, "R9"); chk_regs("R9 read");
    xfer(32'h21, 8, "R6");  chk_regs("R6 disarm");
    xfer(32'h00AA, 16, "R6"); chk_regs("R6 no read");

    // R10 enable rises while clock high
    begin_xfer();
    for (int i = 7; i >= 0; i--) bit_xfer(1'b1, "R10");
    repeat (HP) @(negedge clk);
    sck = 1'b1; repeat (HP) @(negedge clk);
    sen_n = 1'b1; m_act = 0; m_sync = 0; settle = 8;
    repeat (HP) @(negedge clk);
    sck = 1'b0; m_sync = 1; repeat (2 * HP) @(negedge clk);
    chk_regs("R10 abort on rise");
    // R10 enable falls while clock high
    sck = 1'b1; repeat (HP) @(negedge clk);
    sen_n = 1'b0; m_sync = 0; m_act = 0;
    repeat (HP) @(negedge clk);
    sck = 1'b0; repeat (HP) @(negedge clk);
    for (int i = 7; i >= 0; i--) bit_xfer(1'b0, "R10");
    end_xfer();
    chk_regs("R10 abort on fall");
    xfer(32'h5C, 8, "R10"); chk_regs("R10 resync");

    // R12 reset mid-run
    @(negedge clk);
    rst_n = 1'b0; settle = 4;
    m_ctl = 0; m_div = 0; m_ref = 0;
    repeat (2) @(negedge clk);
    chk_regs("R12 reset clears");
    chk(sdo_oe == 0, "R12", "oe after reset", 32'(sdo_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(32'hBEEF, 16, "R2"); chk_regs("R2 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule